// File: doc/BRIEF.md
# Rotating Phase-Shifted Multi-String PWM

This block produces one on/off enable per parallel LED string from a single dimming command. There are a power-of-two number of strings. The PWM period is cut into as many coarse slots as there are strings, and each slot is cut into a power-of-two number of fine ticks. The upper bits of the command say how many strings conduct for a whole slot. The window of conducting strings moves forward by one string at every slot boundary, so the strings are evenly phase shifted. The total load never steps by more than one string's current.

The lower bits of the command give sub-slot resolution. The string just past the end of the window also conducts for the first few fine ticks of each slot, so each pulse gets a short tail on its trailing edge. The command is captured only when a slot ends, which avoids runt pulses. A tick enable paces the fine counter, so the PWM rate can be set by an external prescaler.

Top module: `pspwm_rotor`

## Requirements
- R1: While reset is asserted at a clock edge, the next cycle shows every enable low and the slot index at 0.
- R2: The command is split as follows. Bits [CMD_W-1 : CMD_W-log2(N_STR)] form the coarse count C, and the remaining low bits form the fine count F. In every cycle the number of asserted enables is C or C+1, and it is C+1 only while F is nonzero.
- R3: Over one full period of N_STR slots with a steady command, each enable is high for exactly C*2^FINE_W + F enabled ticks. With the defaults, 0x66 gives 102 ticks out of 256.
- R4: In slot k with fine position f, the strings k through k+C-1 (mod N_STR) are enabled. String k+C (mod N_STR) is enabled only while f < F. All other strings are low.
- R5: The fine position advances only on cycles with tick_en high. The slot index steps by one (mod N_STR) after every 2^FINE_W enabled ticks. While tick_en is low, the enables and the slot index hold.
- R6: The command is captured only on the enabled tick that ends a slot. A change in the middle of a slot leaves the enables unchanged until the next slot begins.
- R7: A captured command of zero keeps every enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Advances the fine position by one when high |
| dim_cmd | input | CMD_W | Dimming command: coarse count in the high bits, fine count in the low bits |
| str_en | output | N_STR | One enable per string current sink |
| slot_idx | output | log2(N_STR) | Index of the current coarse slot |

## Verification
The hardest case to reach from the ports is a command that changes in the middle of a slot. For the rest of that slot the old pattern must still be seen, and the new pattern must appear exactly at the next boundary. The bench gets there by first locking onto a slot boundary, which it finds by watching slot_idx change. It then counts fine ticks itself and changes the command ten ticks into a slot. The same boundary lock supports two other tests: whole-period per-string tick counts for every command in the table, and a tick_en stall placed in the middle of a slot.

// File: rtl/pspwm_pkg.sv
// Package pspwm_pkg
// Shared helpers for the rotating phase-shifted PWM.
// Assumes the string count is a power of two.
package pspwm_pkg;

    // Distance of a lane ahead of the current slot, taken around the ring of strings.
    function automatic int ring_gap(input int lane, input int slot, input int n_str);
        return (lane - slot + n_str) % n_str;
    endfunction

endpackage

// File: rtl/pspwm_timebase.sv
// Module pspwm_timebase
// Holds the fine tick counter and the coarse slot counter.
// Captures the dimming command on the enabled tick that closes a slot.
// Assumes tick_en is synchronous to clk. Reset is synchronous and active low.
module pspwm_timebase #(
    parameter int N_STR = 8,
    parameter int CMD_W = 8,
    localparam int COARSE_W = $clog2(N_STR),
    localparam int FINE_W   = CMD_W - COARSE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic [CMD_W-1:0]    dim_cmd,
    output logic [FINE_W-1:0]   fine_q,
    output logic [COARSE_W-1:0] slot_q,
    output logic [COARSE_W-1:0] coarse_q,
    output logic [FINE_W-1:0]   frac_q
);

    logic [CMD_W-1:0] cmd_q;
    logic             slot_end;

    // Flag the enabled tick that ends the current slot.
    assign slot_end = tick_en && (fine_q == {FINE_W{1'b1}});

    // Advance the counters and capture the command at slot ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fine_q <= '0;
            slot_q <= '0;
            cmd_q  <= '0;
        end else if (tick_en) begin
            fine_q <= fine_q + 1'b1;
            if (slot_end) begin
                slot_q <= slot_q + 1'b1;
                cmd_q  <= dim_cmd;
            end
        end
    end

    // Split the captured command into its coarse and fine parts.
    assign coarse_q = cmd_q[CMD_W-1 -: COARSE_W];
    assign frac_q   = cmd_q[FINE_W-1:0];

    // R5
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_end |=> (slot_q == $past(slot_q) + 1'b1));

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en) |=> ($stable(fine_q) && $stable(slot_q)));

    // R6
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_end) |=> ($stable(coarse_q) && $stable(frac_q)));

endmodule

// File: rtl/pspwm_lane.sv
// Module pspwm_lane
// Decides the enable of one string from its distance ahead of the current slot.
// The lane is fully on inside the window and gets a short tail just past it.
// Assumes LANE_IDX < N_STR.
module pspwm_lane #(
    parameter int N_STR    = 8,
    parameter int CMD_W    = 8,
    parameter int LANE_IDX = 0,
    localparam int COARSE_W = $clog2(N_STR),
    localparam int FINE_W   = CMD_W - COARSE_W
) (
    input  logic [COARSE_W-1:0] slot_q,
    input  logic [FINE_W-1:0]   fine_q,
    input  logic [COARSE_W-1:0] coarse_q,
    input  logic [FINE_W-1:0]   frac_q,
    output logic                en
);

    int gap;

    // Work out the window membership, and the tail, of this lane.
    always_comb begin
        gap = pspwm_pkg::ring_gap(LANE_IDX, int'(slot_q), N_STR);
        en  = (gap < int'(coarse_q)) ||
              ((gap == int'(coarse_q)) && (fine_q < frac_q));
    end

endmodule

// File: rtl/pspwm_rotor.sv
// Module pspwm_rotor
// Top level of the rotating phase-shifted multi-string PWM.
// Builds one lane per string around a shared timebase.
// Assumes N_STR is a power of two of at least 2, and CMD_W > log2(N_STR).
module pspwm_rotor #(
    parameter int N_STR = 8,
    parameter int CMD_W = 8,
    localparam int COARSE_W = $clog2(N_STR),
    localparam int FINE_W   = CMD_W - COARSE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic [CMD_W-1:0]    dim_cmd,
    output logic [N_STR-1:0]    str_en,
    output logic [COARSE_W-1:0] slot_idx
);

    logic [FINE_W-1:0]   fine_q;
    logic [COARSE_W-1:0] slot_q;
    logic [COARSE_W-1:0] coarse_q;
    logic [FINE_W-1:0]   frac_q;

    pspwm_timebase #(.N_STR(N_STR), .CMD_W(CMD_W)) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .dim_cmd  (dim_cmd),
        .fine_q   (fine_q),
        .slot_q   (slot_q),
        .coarse_q (coarse_q),
        .frac_q   (frac_q)
    );

    // One decision lane per string.
    for (genvar i = 0; i < N_STR; i++) begin : g_lane
        pspwm_lane #(.N_STR(N_STR), .CMD_W(CMD_W), .LANE_IDX(i)) u_lane (
            .slot_q   (slot_q),
            .fine_q   (fine_q),
            .coarse_q (coarse_q),
            .frac_q   (frac_q),
            .en       (str_en[i])
        );
    end

    assign slot_idx = slot_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        (!rst_n) |=> ((str_en == '0) && (slot_idx == '0)));

    // R2
    active_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(str_en) == int'(coarse_q)) ||
        (($countones(str_en) == int'(coarse_q) + 1) && (frac_q != '0)));

    // R7
    zero_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((coarse_q == '0) && (frac_q == '0)) |-> (str_en == '0));

endmodule

// File: tb/pspwm_rotor_tb.sv
// Bench for pspwm_rotor: a table of commands walked by one loop, then directed tests.
module pspwm_rotor_tb;

    localparam int N_STR    = 8;
    localparam int CMD_W    = 8;
    localparam int COARSE_W = $clog2(N_STR);
    localparam int FINE_W   = CMD_W - COARSE_W;
    localparam int TICKS    = 1 << FINE_W;
    localparam int PERIOD   = N_STR * TICKS;
    localparam int NVEC     = 6;

    // Each command paired with its expected per-string high ticks per period.
    localparam logic [CMD_W-1:0] VEC_CMD [NVEC] = '{8'h66, 8'h01, 8'h20, 8'hFF, 8'hE0, 8'h1F};
    localparam int               VEC_ON  [NVEC] = '{102, 1, 32, 255, 224, 31};

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                tick_en = 1'b0;
    logic [CMD_W-1:0]    dim_cmd = '0;
    logic [N_STR-1:0]    str_en;
    logic [COARSE_W-1:0] slot_idx;

    int n_run = 0;
    int n_fail = 0;
    int tb_fine = 0;
    int exp_slot = 0;
    bit done = 1'b0;

    pspwm_rotor #(.N_STR(N_STR), .CMD_W(CMD_W)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .dim_cmd  (dim_cmd),
        .str_en   (str_en),
        .slot_idx (slot_idx)
    );

    always #10 clk = ~clk;

    // Move one edge forward and settle after it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Record one check; print the failure line if it did not pass.
    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Step until the slot index changes, then align the bench's own tick count.
    task automatic sync_slot();
        logic [COARSE_W-1:0] prev;
        tick_en = 1'b1;
        prev = slot_idx;
        for (int i = 0; i < TICKS + 2; i++) begin
            step();
            if (slot_idx != prev) break;
        end
        tb_fine = 0;
        exp_slot = int'(slot_idx);
    endtask

    // Run enabled ticks and compare each cycle with the placement rule. Returns the mismatch count.
    task automatic run_ticks(input int n, input int c, input int f, output int bad, output int on_cnt [N_STR]);
        bad = 0;
        for (int s = 0; s < N_STR; s++) on_cnt[s] = 0;
        for (int t = 0; t < n; t++) begin
            int ones;
            ones = 0;
            if (int'(slot_idx) != exp_slot) bad++;
            for (int s = 0; s < N_STR; s++) begin
                int g;
                bit e;
                g = (s - exp_slot + N_STR) % N_STR;
                e = (g < c) || ((g == c) && (tb_fine < f));
                if (str_en[s] != e) bad++;
                if (str_en[s]) begin
                    on_cnt[s]++;
                    ones++;
                end
            end
            if (!((ones == c) || ((ones == c + 1) && (f != 0)))) bad++;
            tick_en = 1'b1;
            step();
            tb_fine++;
            if (tb_fine == TICKS) begin
                tb_fine = 0;
                exp_slot = (exp_slot + 1) % N_STR;
            end
        end
    endtask

    // End a hung run as a failure.
    initial begin
        #(200000 * 20);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int bad;
        int cnt [N_STR];
        int c;
        int f;

        // R1: reset state
        rst_n = 1'b0;
        tick_en = 1'b1;
        dim_cmd = 8'hFF;
        step();
        step();
        check(str_en == '0, "R1", "enables in reset", int'(str_en), 0);
        check(slot_idx == '0, "R1", "slot index in reset", int'(slot_idx), 0);
        rst_n = 1'b1;

        // R2 R3 R4: walk the command table, one full period each
        for (int v = 0; v < NVEC; v++) begin
            dim_cmd = VEC_CMD[v];
            c = int'(VEC_CMD[v][CMD_W-1 -: COARSE_W]);
            f = int'(VEC_CMD[v][FINE_W-1:0]);
            sync_slot();
            run_ticks(PERIOD, c, f, bad, cnt);
            check(bad == 0, "R4", $sformatf("placement cmd 0x%0h mismatches", VEC_CMD[v]), bad, 0);
            for (int s = 0; s < N_STR; s++)
                check(cnt[s] == VEC_ON[v], "R3", $sformatf("ticks on, string %0d cmd 0x%0h", s, VEC_CMD[v]), cnt[s], VEC_ON[v]);
            check(cnt[0] == c * TICKS + f, "R2", "coarse/fine split", cnt[0], c * TICKS + f);
        end

        // R7: a zero command keeps everything dark
        dim_cmd = '0;
        sync_slot();
        run_ticks(PERIOD, 0, 0, bad, cnt);
        begin
            int tot;
            tot = 0;
            for (int s = 0; s < N_STR; s++) tot += cnt[s];
            check(tot == 0, "R7", "high ticks with zero command", tot, 0);
        end

        // R5: a stall in mid-slot holds enables and slot index
        dim_cmd = 8'h66;
        sync_slot();
        run_ticks(3, 3, 6, bad, cnt);
        begin
            logic [N_STR-1:0]    snap_en;
            logic [COARSE_W-1:0] snap_slot;
            int moved;
            moved = 0;
            snap_en = str_en;
            snap_slot = slot_idx;
            tick_en = 1'b0;
            for (int i = 0; i < 40; i++) begin
                step();
                if (str_en != snap_en || slot_idx != snap_slot) moved++;
            end
            check(moved == 0, "R5", "changes while tick_en low", moved, 0);
        end
        run_ticks(PERIOD - 3, 3, 6, bad, cnt);
        check(bad == 0, "R5", "placement after stall mismatches", bad, 0);
        check(int'(slot_idx) == exp_slot, "R5", "slot index after stall", int'(slot_idx), exp_slot);

        // R6: a command change mid-slot waits for the boundary
        sync_slot();
        run_ticks(10, 3, 6, bad, cnt);
        dim_cmd = 8'h20;
        run_ticks(TICKS - 10, 3, 6, bad, cnt);
        check(bad == 0, "R6", "old pattern for rest of slot mismatches", bad, 0);
        run_ticks(TICKS, 1, 0, bad, cnt);
        check(bad == 0, "R6", "new pattern from next slot mismatches", bad, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule